// File: doc/BRIEF.md
# Interrupt Vector and DMA Request Unit

This unit keeps the event status word and the interrupt-enable mask of a 16-bit memory-mapped serial-bus master. From them it drives one level interrupt line and two DMA request lines, one for receive and one for transmit. The transfer engine and the data buffer raise events through one-cycle set pulses, and they withdraw the two data-ready events through hardware clear pulses. A live bus-busy level is merged into status read-back but is never stored.

Software reaches the unit over a simple register bus with word addresses: 0 status, 1 interrupt enable, 2 vector, 3 DMA control, 4 test. A revision parameter picks the register behaviour. Below revision 0x34, status is read-only and the vector register acknowledges events. From 0x34 up, status is write-one-to-clear and the test register can force events. Writing the DMA control register hands the data-ready events over to the DMA lines by removing their interrupt enables.

Top module: `irqv_unit`

## Requirements
- R1: After reset, status, enable and DMA control read 0, and irq, drq_rx and drq_tx are low.
- R2: irq is high exactly when status AND enable is nonzero, counted from the clock edge that updated either register.
- R3: A hw_set bit sets the matching stored status bit (stored bits are 0-5, 10, 11 and 15). A set wins over any clear in the same cycle.
- R4: At revision 0x34 or above, a status write clears only the bits that are set in both wdata and 0x0027, so bits 3 and 4 survive it. Below 0x34 a status write changes nothing.
- R5: Below revision 0x34, a vector read returns the index plus one of the lowest set bit of status AND enable, and clears that status bit. It returns 0 when nothing is pending. At 0x34 or above the vector register reads 0 and clears nothing.
- R6: The enable register keeps bits 4:0 below revision 0x34 and bits 5:0 from 0x34 on.
- R7: The DMA control register keeps only bit 15 (receive) and bit 7 (transmit). Writing bit 15 as 1 clears enable bit 3, and writing bit 7 as 1 clears enable bit 4.
- R8: drq_rx equals status bit 3 while DMA bit 15 is set, and drq_tx equals status bit 4 while DMA bit 7 is set. A request whose DMA bit is clear stays low.
- R9: At revision 0x34 or above, a test-register write with bit 11 set sets status bits 5:0. Below 0x34 it has no effect.
- R10: A status read returns bit 12 equal to bus_busy in the cycle of the read.
- R11: A hw_clr bit clears the matching stored status bit unless a set hits it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, one cycle after bus_rd, 0 otherwise |
| hw_set | input | DW | Event set pulses from the engine and buffer |
| hw_clr | input | DW | Hardware clear pulses (data-ready withdrawal) |
| bus_busy | input | 1 | Live bus-busy level |
| irq | output | 1 | Interrupt request level |
| drq_rx | output | 1 | Receive DMA request |
| drq_tx | output | 1 | Transmit DMA request |

## Verification
Two instances, one on each side of the revision split, share the same stimulus. A set pulse on a single bit lets the vector code, the write-one-to-clear path and the interrupt level each be told apart. Several pending bits, some of them disabled, expose the lowest-bit ordering and show that masked events are skipped. Set pulses that collide with a status write or a hardware clear show set priority, and DMA takeover with both ready bits pending separates the request lines from the interrupt. A long random phase of reads, writes and pulses is then compared every cycle against a behavioural model.

// File: rtl/irqv_pkg.sv
// Shared constants for the interrupt vector / DMA request unit.
// Assumes a 16-bit data path; bit positions are fixed by the register layout.
package irqv_pkg;
    localparam int A_STAT = 0;
    localparam int A_IEN  = 1;
    localparam int A_VEC  = 2;
    localparam int A_DMA  = 3;
    localparam int A_TEST = 4;

    localparam int B_NACK  = 1;
    localparam int B_ARDY  = 2;
    localparam int B_RRDY  = 3;
    localparam int B_XRDY  = 4;
    localparam int B_XUDF  = 10;
    localparam int B_ROVR  = 11;
    localparam int B_BUSY  = 12;
    localparam int B_SBD   = 15;

    localparam int B_RX_DMA     = 15;
    localparam int B_TX_DMA     = 7;
    localparam int B_TEST_FORCE = 11;

    localparam logic [15:0] STORE_MASK  = 16'h8C3F;
    localparam logic [15:0] SW_CLR_MASK = 16'h0027;
    localparam logic [15:0] FORCE_MASK  = 16'h003F;
    localparam logic [15:0] DMA_MASK    = 16'h8080;
    localparam logic [15:0] IEN_OLD     = 16'h001F;
    localparam logic [15:0] IEN_NEW     = 16'h003F;

    localparam logic [7:0] REV_SPLIT = 8'h34;
endpackage

// File: rtl/irqv_vector.sv
// Lowest-set-bit finder for the interrupt vector.
// Produces the one-hot lowest pending bit and its index plus one (0 if none).
// Assumes DW is small enough for a linear priority chain.
module irqv_vector #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] pending,
    output logic [DW-1:0] onehot,
    output logic [DW-1:0] code
);
    logic [DW:0] seen;

    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < DW; i++) begin : g_chain
            assign seen[i+1]  = seen[i] | pending[i];
            assign onehot[i]  = pending[i] & ~seen[i];
        end
    endgenerate

    // Encode the one-hot winner as index plus one.
    always_comb begin
        code = '0;
        for (int k = 0; k < DW; k++) begin
            if (onehot[k]) code = DW'(k + 1);
        end
    end

    // R5: a nonzero code appears exactly when something is pending
    always_comb begin
        a_code_zero_r5: assert ((pending == '0) == (code == '0));
    end
endmodule

// File: rtl/irqv_status_reg.sv
// Stored event status word.
// Combines hardware set/clear pulses, software write-one-to-clear, vector
// acknowledge and test-force; sets take priority over every clear.
// Assumes at most one software access per cycle.
module irqv_status_reg
    import irqv_pkg::*;
#(
    parameter logic [7:0] REV = 8'h20,
    parameter int         DW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] hw_set,
    input  logic [DW-1:0] hw_clr,
    input  logic          sw_clr_wr,
    input  logic [DW-1:0] sw_wdata,
    input  logic          force_wr,
    input  logic [DW-1:0] ack_onehot,
    output logic [DW-1:0] status_q,
    output logic [DW-1:0] status_d
);
    localparam bit            NEW_REV = (REV >= REV_SPLIT);
    localparam logic [DW-1:0] KEEP    = DW'(STORE_MASK);
    localparam logic [DW-1:0] SWCLR   = DW'(SW_CLR_MASK);
    localparam logic [DW-1:0] FORCE   = DW'(FORCE_MASK);

    logic [DW-1:0] clr_vec;
    logic [DW-1:0] set_vec;

    // Gather every clear source active this cycle.
    always_comb begin
        clr_vec = hw_clr | ack_onehot;
        if (NEW_REV && sw_clr_wr) clr_vec = clr_vec | (sw_wdata & SWCLR);
    end

    // Gather every set source active this cycle.
    always_comb begin
        set_vec = hw_set;
        if (NEW_REV && force_wr && sw_wdata[B_TEST_FORCE]) set_vec = set_vec | FORCE;
    end

    // Next status: clear first, then set, keep stored bits only.
    always_comb begin
        status_d = ((status_q & ~clr_vec) | set_vec) & KEEP;
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // R3: set pulses always land, regardless of same-cycle clears
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_set & KEEP)) |=> ((status_q & $past(hw_set & KEEP)) == $past(hw_set & KEEP)));

    // R4: receive-ready survives anything but hardware clear or acknowledge
    p_rrdy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[B_RRDY] && !hw_clr[B_RRDY] && !ack_onehot[B_RRDY]) |=> status_q[B_RRDY]);

    // R4: transmit-ready survives anything but hardware clear or acknowledge
    p_xrdy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[B_XRDY] && !hw_clr[B_XRDY] && !ack_onehot[B_XRDY]) |=> status_q[B_XRDY]);
endmodule

// File: rtl/irqv_ctrl_regs.sv
// Interrupt-enable mask and DMA control register.
// A DMA write removes the enables of the data-ready events it takes over.
// Assumes enable and DMA writes never share a cycle (single bus).
module irqv_ctrl_regs
    import irqv_pkg::*;
#(
    parameter logic [7:0] REV = 8'h20,
    parameter int         DW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr,
    input  logic          dma_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] en_d,
    output logic [DW-1:0] dma_q,
    output logic [DW-1:0] dma_d
);
    localparam logic [DW-1:0] EN_MASK = (REV >= REV_SPLIT) ? DW'(IEN_NEW) : DW'(IEN_OLD);
    localparam logic [DW-1:0] DMAKEEP = DW'(DMA_MASK);

    // Next enable mask: direct write, or DMA takeover removing ready enables.
    always_comb begin
        en_d = en_q;
        if (en_wr) begin
            en_d = wdata & EN_MASK;
        end else if (dma_wr) begin
            if (wdata[B_RX_DMA]) en_d[B_RRDY] = 1'b0;
            if (wdata[B_TX_DMA]) en_d[B_XRDY] = 1'b0;
        end
    end

    // Next DMA control value.
    always_comb begin
        dma_d = dma_wr ? (wdata & DMAKEEP) : dma_q;
    end

    // Register update for both control words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            dma_q <= '0;
        end else begin
            en_q  <= en_d;
            dma_q <= dma_d;
        end
    end

    // R6: enable writes keep only the revision's bit range
    p_en_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_q == ($past(wdata) & EN_MASK)));

    // R7: receive DMA takeover removes the receive-ready enable
    p_rx_steal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && wdata[B_RX_DMA]) |=> !en_q[B_RRDY]);

    // R7: transmit DMA takeover removes the transmit-ready enable
    p_tx_steal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && wdata[B_TX_DMA]) |=> !en_q[B_XRDY]);
endmodule

// File: rtl/irqv_unit.sv
// Interrupt vector and DMA request unit (top).
// Decodes the register bus, holds status/enable/DMA state, registers the
// interrupt and DMA request outputs, and returns registered read data.
// Assumes bus_wr and bus_rd are not both high in one cycle.
module irqv_unit
    import irqv_pkg::*;
#(
    parameter logic [7:0] REV    = 8'h20,
    parameter int         ADDR_W = 3,
    parameter int         DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     hw_set,
    input  logic [DW-1:0]     hw_clr,
    input  logic              bus_busy,
    output logic              irq,
    output logic              drq_rx,
    output logic              drq_tx
);
    logic hit_stat, hit_ien, hit_vec, hit_dma, hit_test;
    logic [DW-1:0] status_q, status_d;
    logic [DW-1:0] en_q, en_d, dma_q, dma_d;
    logic [DW-1:0] ack_onehot, vec_val, rd_val;

    // Address decode.
    always_comb begin
        hit_stat = (int'(bus_addr) == A_STAT);
        hit_ien  = (int'(bus_addr) == A_IEN);
        hit_vec  = (int'(bus_addr) == A_VEC);
        hit_dma  = (int'(bus_addr) == A_DMA);
        hit_test = (int'(bus_addr) == A_TEST);
    end

    irqv_status_reg #(.REV(REV), .DW(DW)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_set     (hw_set),
        .hw_clr     (hw_clr),
        .sw_clr_wr  (bus_wr & hit_stat),
        .sw_wdata   (bus_wdata),
        .force_wr   (bus_wr & hit_test),
        .ack_onehot (ack_onehot),
        .status_q   (status_q),
        .status_d   (status_d)
    );

    irqv_ctrl_regs #(.REV(REV), .DW(DW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (bus_wr & hit_ien),
        .dma_wr (bus_wr & hit_dma),
        .wdata  (bus_wdata),
        .en_q   (en_q),
        .en_d   (en_d),
        .dma_q  (dma_q),
        .dma_d  (dma_d)
    );

    generate
        if (REV < REV_SPLIT) begin : g_vec
            logic [DW-1:0] pending, onehot, code;
            assign pending = status_q & en_q;

            irqv_vector #(.DW(DW)) u_vec (
                .pending (pending),
                .onehot  (onehot),
                .code    (code)
            );

            assign ack_onehot = (bus_rd && hit_vec) ? onehot : '0;
            assign vec_val    = code;

            // R5: a vector read with a pending source returns a nonzero code
            p_vec_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_rd && hit_vec && (|pending)) |=> (bus_rdata != '0));
        end else begin : g_novec
            assign ack_onehot = '0;
            assign vec_val    = '0;
        end
    endgenerate

    // Read multiplexer; busy level merged live into bit 12 of status.
    always_comb begin
        rd_val = '0;
        if (hit_stat)     rd_val = status_q | (DW'(bus_busy) << B_BUSY);
        else if (hit_ien) rd_val = en_q;
        else if (hit_vec) rd_val = vec_val;
        else if (hit_dma) rd_val = dma_q;
    end

    // Registered read data, zero when no read was issued.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
        else             bus_rdata <= '0;
    end

    // Registered interrupt and DMA request lines, aligned with the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq    <= 1'b0;
            drq_rx <= 1'b0;
            drq_tx <= 1'b0;
        end else begin
            irq    <= |(status_d & en_d);
            drq_rx <= dma_d[B_RX_DMA] & status_d[B_RRDY];
            drq_tx <= dma_d[B_TX_DMA] & status_d[B_XRDY];
        end
    end

    // R2: interrupt level tracks status AND enable
    p_irq_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(status_q & en_q)));

    // R8: receive request held low without receive DMA
    p_drq_rx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_q[B_RX_DMA] |-> !drq_rx);

    // R8: transmit request held low without transmit DMA
    p_drq_tx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_q[B_TX_DMA] |-> !drq_tx);

    // R10: status read returns the busy level of the read cycle
    p_busy_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_stat) |=> (bus_rdata[B_BUSY] == $past(bus_busy)));
endmodule

// File: tb/irqv_unit_test.sv
`timescale 1ns/1ps
// Bench: two instances (older and newer revision) on shared stimulus,
// a behavioural model updated each clock, and directed plus random phases.
module irqv_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0, busy = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0, hset = '0, hclr = '0;
    logic [15:0] rdata0, rdata1;
    logic        irq0, irq1, drx0, drx1, dtx0, dtx1;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    bit live  = 1'b0;

    always #2.5 clk = ~clk;

    irqv_unit #(.REV(8'h20)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata0), .hw_set(hset), .hw_clr(hclr),
        .bus_busy(busy), .irq(irq0), .drq_rx(drx0), .drq_tx(dtx0));

    irqv_unit #(.REV(8'h34)) uut_new (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata1), .hw_set(hset), .hw_clr(hclr),
        .bus_busy(busy), .irq(irq1), .drq_rx(drx1), .drq_tx(dtx1));

    // Behavioural model state, index 0 = older revision, 1 = newer.
    logic [15:0] m_st[2], m_en[2], m_dma[2], m_rd[2];

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            logic [15:0] clr, set, p;
            bit newer;
            newer = (k == 1);
            if (!rst_n) begin
                m_st[k] = 0; m_en[k] = 0; m_dma[k] = 0; m_rd[k] = 0;
            end else begin
                clr = hclr; set = hset; m_rd[k] = 0;
                if (rd) begin
                    case (addr)
                        3'd0: m_rd[k] = m_st[k] | (busy ? 16'h1000 : 16'h0);
                        3'd1: m_rd[k] = m_en[k];
                        3'd2: if (!newer) begin
                                  p = m_st[k] & m_en[k];
                                  for (int b = 15; b >= 0; b--)
                                      if (p[b]) m_rd[k] = 16'(b + 1);
                                  if (m_rd[k] != 0) clr[m_rd[k] - 1] = 1'b1;
                              end
                        3'd3: m_rd[k] = m_dma[k];
                        default: m_rd[k] = 0;
                    endcase
                end
                if (wr) begin
                    case (addr)
                        3'd0: if (newer) clr = clr | (wdata & 16'h0027);
                        3'd1: m_en[k] = wdata & (newer ? 16'h003F : 16'h001F);
                        3'd3: begin
                                  m_dma[k] = wdata & 16'h8080;
                                  if (wdata[15]) m_en[k][3] = 1'b0;
                                  if (wdata[7])  m_en[k][4] = 1'b0;
                              end
                        3'd4: if (newer && wdata[11]) set = set | 16'h003F;
                        default: ;
                    endcase
                end
                m_st[k] = ((m_st[k] & ~clr) | set) & 16'h8C3F;
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Output lines compared with the model on every clock.
    always @(negedge clk) begin
        if (live) begin
            chk("R2 irq old",    {15'b0, irq0}, {15'b0, |(m_st[0] & m_en[0])});
            chk("R2 irq new",    {15'b0, irq1}, {15'b0, |(m_st[1] & m_en[1])});
            chk("R8 drq_rx old", {15'b0, drx0}, {15'b0, m_dma[0][15] & m_st[0][3]});
            chk("R8 drq_rx new", {15'b0, drx1}, {15'b0, m_dma[1][15] & m_st[1][3]});
            chk("R8 drq_tx old", {15'b0, dtx0}, {15'b0, m_dma[0][7] & m_st[0][4]});
            chk("R8 drq_tx new", {15'b0, dtx1}, {15'b0, m_dma[1][7] & m_st[1][4]});
        end
    end

    task automatic op(input logic w, input logic r, input logic [2:0] a,
                      input logic [15:0] d, input logic [15:0] s, input logic [15:0] c);
        @(negedge clk);
        wr = w; rd = r; addr = a; wdata = d; hset = s; hclr = c;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; hset = '0; hclr = '0;
    endtask

    task automatic rd_hard(input string tag, input logic [2:0] a,
                           input logic [15:0] e0, input logic [15:0] e1);
        op(1'b0, 1'b1, a, 16'h0, 16'h0, 16'h0);
        chk({tag, " old"}, rdata0, e0);
        chk({tag, " new"}, rdata1, e1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        live = 1'b1;
        // R1 reset state
        chk("R1 irq old", {15'b0, irq0}, 16'h0);
        chk("R1 drq new", {14'b0, drx1, dtx1}, 16'h0);
        rd_hard("R1 status", 3'd0, 16'h0, 16'h0);
        rd_hard("R1 dma", 3'd3, 16'h0, 16'h0);
        // R6 enable width
        op(1'b1, 1'b0, 3'd1, 16'hFFFF, 0, 0);
        rd_hard("R6 enable", 3'd1, 16'h001F, 16'h003F);
        // R3 set, R2 irq
        op(1'b0, 1'b0, 3'd0, 0, 16'h0004, 0);
        chk("R2 irq high old", {15'b0, irq0}, 16'h1);
        chk("R2 irq high new", {15'b0, irq1}, 16'h1);
        // R5 vector
        rd_hard("R5 vector single", 3'd2, 16'h0003, 16'h0000);
        chk("R5 ack drops irq old", {15'b0, irq0}, 16'h0);
        rd_hard("R5 status after ack", 3'd0, 16'h0000, 16'h0004);
        // R4 write-one-to-clear
        op(1'b0, 1'b0, 3'd0, 0, 16'h000A, 0);
        op(1'b1, 1'b0, 3'd0, 16'hFFFF, 0, 0);
        rd_hard("R4 status w1c", 3'd0, 16'h000A, 16'h0008);
        // R3 set beats same-cycle clear
        op(1'b1, 1'b0, 3'd0, 16'h0002, 16'h0002, 0);
        rd_hard("R3 set wins", 3'd0, 16'h000A, 16'h000A);
        // R11 hardware clear
        op(1'b0, 1'b0, 3'd0, 0, 0, 16'h0008);
        rd_hard("R11 hw clear", 3'd0, 16'h0002, 16'h0002);
        // R5 ordering with a disabled source
        op(1'b0, 1'b0, 3'd0, 0, 16'h0030, 0);
        rd_hard("R5 vector lowest", 3'd2, 16'h0002, 16'h0000);
        rd_hard("R5 vector next", 3'd2, 16'h0005, 16'h0000);
        rd_hard("R5 vector masked", 3'd2, 16'h0000, 16'h0000);
        // R7 DMA register and enable takeover
        op(1'b1, 1'b0, 3'd3, 16'hFFFF, 0, 0);
        rd_hard("R7 dma bits", 3'd3, 16'h8080, 16'h8080);
        rd_hard("R7 enable stolen", 3'd1, 16'h0007, 16'h0027);
        // R8 requests follow ready bits
        op(1'b0, 1'b0, 3'd0, 0, 16'h0018, 0);
        chk("R8 both requests old", {14'b0, drx0, dtx0}, 16'h0003);
        chk("R8 both requests new", {14'b0, drx1, dtx1}, 16'h0003);
        chk("R7 no irq from ready old", {15'b0, irq0}, 16'h0);
        op(1'b1, 1'b0, 3'd3, 16'h0000, 0, 0);
        chk("R8 requests gated new", {14'b0, drx1, dtx1}, 16'h0);
        // R4 ready bits survive software clear
        op(1'b1, 1'b0, 3'd0, 16'hFFFF, 0, 0);
        rd_hard("R4 ready kept", 3'd0, 16'h0038, 16'h0018);
        // R9 test force
        op(1'b1, 1'b0, 3'd4, 16'h0800, 0, 0);
        rd_hard("R9 force", 3'd0, 16'h0038, 16'h003F);
        // R10 busy level
        busy = 1'b1;
        rd_hard("R10 busy", 3'd0, 16'h1038, 16'h103F);
        busy = 1'b0;
        // Random phase against the model.
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] kind;
            logic [15:0] s, c;
            kind = 3'($urandom_range(0, 7));
            s = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
            c = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
            busy = 1'($urandom);
            if (kind < 3) begin
                op(1'b0, 1'b1, 3'($urandom_range(0, 7)), 0, s, c);
                chk("R5 R10 random read old", rdata0, m_rd[0]);
                chk("R5 R10 random read new", rdata1, m_rd[1]);
            end else if (kind < 6) begin
                op(1'b1, 1'b0, 3'($urandom_range(0, 7)), 16'($urandom), s, c);
            end else begin
                op(1'b0, 1'b0, 3'd0, 0, s, c);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule